// File: doc/BRIEF.md
# Snoop-Driven Cache Invalidation Unit

This unit keeps a small on-chip cache directory coherent when another bus master writes to external memory. An outside agent first raises an address-hold request. The unit responds by letting go of the shared address lines: its output enable drops on the clock after the request is seen. The agent then drives a snooped address and pulls an active-low address-valid strobe. The unit latches that address and looks it up in a direct-mapped tag directory. If it finds a matching valid line, it clears that line's valid bit.

The address lines are bidirectional. At this block's edge they appear as three separate signals: an input (`addr_in`), an output (`addr_out`, which carries the processor's own address) and an output enable (`addr_oe`). Lines enter the directory through a fill port that uses a valid/ready handshake. `fill_ready` is always high, so a fill is accepted on every edge where `fill_valid` is high. The fill port never applies back-pressure, and the requester never needs to hold `fill_valid` for more than one cycle. A one-cycle `inval_hit` pulse reports each line that a snoop invalidates.

With the default parameters the directory has 16 lines of 16 bytes each over a 32-bit address. Address bits [3:0] are the byte offset, bits [7:4] are the line index and bits [31:8] are the tag.

Top module: `snoop_inval_unit`

## Requirements
- R1: While and after reset, every directory line is invalid, `addr_oe` is 1 and `inval_hit` is 0.
- R2: When `ahold` is 1 at a rising edge, `addr_oe` is 0 from that edge until the next edge.
- R3: When `ahold` is 0 at a rising edge, `addr_oe` is 1 from that edge until the next edge.
- R4: At a rising edge where `ahold` is 1 and `eads_n` is 0, the unit captures `addr_in` as the snoop address.
- R5: If a captured address has the same index (bits [7:4]) and tag (bits [31:8]) as a valid line, that line becomes invalid at the next edge, and `inval_hit` is 1 for exactly the one cycle after that edge.
- R6: A captured address that matches no valid line changes no line, and `inval_hit` stays 0.
- R7: An edge where `eads_n` is 0 but `ahold` is 0 captures nothing and has no effect on any line or output.
- R8: A fill accepted at an edge (`fill_valid` and `fill_ready` both 1) writes tag bits [31:8] of `fill_addr` into the line selected by bits [7:4] and marks that line valid. Bits [3:0] are ignored. `fill_ready` is always 1.
- R9: If a fill and an invalidation hit the same line at the same edge, the line ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahold | input | 1 | Address-hold request from the external agent |
| eads_n | input | 1 | Active-low strobe: a valid snoop address is on the lines |
| addr_in | input | 32 | Input side of the shared address lines |
| cpu_addr | input | 32 | Address the processor wants to drive |
| addr_out | output | 32 | Output side of the shared address lines |
| addr_oe | output | 1 | Output enable for `addr_out` |
| fill_valid | input | 1 | A fill request is present |
| fill_ready | output | 1 | The fill port can accept a request (always 1) |
| fill_addr | input | 32 | Address of the line being filled |
| inval_hit | output | 1 | One-cycle pulse: a snoop invalidated a line |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, 16-byte lines and a 4-bit index. With only 16 lines, the bench can fill every line, snoop every line, and build tags that alias on index. This exercises hits, misses and the case where a fill and an invalidation reach the same line at the same edge. A behavioural reference model in the bench follows `addr_oe` and `inval_hit` through hold sequences of different lengths and through strobes sent without a hold.

// File: rtl/snoop_inval_pkg.sv
package snoop_inval_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_OFFS_W = 4;
  localparam int unsigned DEF_IDX_W  = 4;

  function automatic int unsigned tag_width(int unsigned aw, int unsigned ow, int unsigned iw);
    return aw - ow - iw;
  endfunction
endpackage

// File: rtl/addr_hold_ctrl.sv
module addr_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ahold,
  output logic addr_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_oe <= 1'b1;
    else        addr_oe <= ~ahold;
  end

  // R2
  release_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ahold |=> !addr_oe);
  // R3
  reclaim_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ahold |=> addr_oe);
endmodule

// File: rtl/snoop_capture.sv
module snoop_capture #(
  parameter int unsigned LA_W = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ahold,
  input  logic            eads_n,
  input  logic [LA_W-1:0] line_addr_in,
  output logic            snp_pend,
  output logic [LA_W-1:0] snp_line
);
  logic take;
  assign take = ahold & ~eads_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_pend <= 1'b0;
      snp_line <= '0;
    end else begin
      snp_pend <= take;
      if (take) snp_line <= line_addr_in;
    end
  end

  // R7
  strobe_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ahold || eads_n) |=> !snp_pend);
  // R4
  capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ahold && !eads_n) |=> (snp_pend && snp_line == $past(line_addr_in)));
endmodule

// File: rtl/line_tag_store.sv
module line_tag_store #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned LINES = 1 << IDX_W,
  localparam int unsigned LA_W  = IDX_W + TAG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [LA_W-1:0] lk_line,
  input  logic            fill_we,
  input  logic [LA_W-1:0] fill_line,
  output logic            inval_hit
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] tag_eq;
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             lk_hit;

  assign lk_idx   = lk_line[IDX_W-1:0];
  assign lk_tag   = lk_line[LA_W-1:IDX_W];
  assign fill_idx = fill_line[IDX_W-1:0];
  assign fill_tag = fill_line[LA_W-1:IDX_W];

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign tag_eq[g] = (tag_q[g] == lk_tag);
  end

  assign lk_hit = lk_valid & valid_q[lk_idx] & tag_eq[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      inval_hit <= 1'b0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      inval_hit <= lk_hit;
      for (int i = 0; i < LINES; i++) begin
        if (lk_hit && lk_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
        end else if (fill_we && fill_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
        end
        if (fill_we && fill_idx == IDX_W'(i)) tag_q[i] <= fill_tag;
      end
    end
  end

  // R5
  hit_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> (!valid_q[$past(lk_idx)] && inval_hit));
  // R6
  miss_keeps_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit && !fill_we) |=> ($stable(valid_q) && !inval_hit));
  // R8
  fill_marks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !(lk_hit && lk_idx == fill_idx)) |=> valid_q[$past(fill_idx)]);
  // R9
  inval_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && lk_hit && lk_idx == fill_idx) |=> !valid_q[$past(fill_idx)]);
endmodule

// File: rtl/snoop_inval_unit.sv
module snoop_inval_unit
  import snoop_inval_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned OFFS_W = DEF_OFFS_W,
  parameter int unsigned IDX_W  = DEF_IDX_W,
  localparam int unsigned TAG_W = tag_width(ADDR_W, OFFS_W, IDX_W),
  localparam int unsigned LA_W  = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ahold,
  input  logic              eads_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              inval_hit
);
  logic            snp_pend;
  logic [LA_W-1:0] snp_line;
  logic            unused_offs;

  assign unused_offs = ^{addr_in[OFFS_W-1:0], fill_addr[OFFS_W-1:0]};
  assign addr_out    = cpu_addr;
  assign fill_ready  = 1'b1;

  addr_hold_ctrl u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .ahold  (ahold),
    .addr_oe(addr_oe)
  );

  snoop_capture #(.LA_W(LA_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .ahold       (ahold),
    .eads_n      (eads_n),
    .line_addr_in(addr_in[ADDR_W-1:OFFS_W]),
    .snp_pend    (snp_pend),
    .snp_line    (snp_line)
  );

  line_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (snp_pend),
    .lk_line  (snp_line),
    .fill_we  (fill_valid & fill_ready),
    .fill_line(fill_addr[ADDR_W-1:OFFS_W]),
    .inval_hit(inval_hit)
  );
endmodule

// File: tb/snoop_inval_unit_test.sv
module snoop_inval_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ahold = 1'b0, eads_n = 1'b1, fill_valid = 1'b0;
  logic [31:0] addr_in = '0, cpu_addr = '0, fill_addr = '0;
  logic [31:0] addr_out;
  logic        addr_oe, fill_ready, inval_hit;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_valid [16];
  int unsigned m_tag   [16];
  bit          m_pend = 0;
  logic [31:0] m_addr = '0;
  bit          e_oe = 1, e_hit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_inval_unit uut (
    .clk(clk), .rst_n(rst_n), .ahold(ahold), .eads_n(eads_n),
    .addr_in(addr_in), .cpu_addr(cpu_addr), .addr_out(addr_out),
    .addr_oe(addr_oe), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .inval_hit(inval_hit)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) m_valid[i] = 0;
      m_pend = 0; e_oe = 1; e_hit = 0;
    end else begin
      automatic int pi = m_addr[7:4];
      automatic int fi = fill_addr[7:4];
      automatic bit hit = m_pend && m_valid[pi] && (m_tag[pi] == m_addr[31:8]);
      if (fill_valid) begin
        m_tag[fi] = fill_addr[31:8];
        m_valid[fi] = 1;
      end
      if (hit) m_valid[pi] = 0;
      e_hit = hit;
      e_oe = !ahold;
      m_pend = ahold && !eads_n;
      if (m_pend) m_addr = addr_in;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (addr_oe !== e_oe) begin
      miscompares++;
      $display("FAIL R2/R3 [%s] addr_oe=%b expected %b at %0t", cur_req, addr_oe, e_oe, $time);
    end
    if (inval_hit !== e_hit) begin
      miscompares++;
      $display("FAIL %s inval_hit=%b expected %b at %0t", cur_req, inval_hit, e_hit, $time);
    end
    if (fill_ready !== 1'b1 || addr_out !== cpu_addr) begin
      miscompares++;
      $display("FAIL R8 fill_ready=%b addr_out=%h expected 1/%h", fill_ready, addr_out, cpu_addr);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic fill(logic [31:0] a);
    fill_valid = 1; fill_addr = a; step();
    fill_valid = 0;
  endtask

  task automatic snoop(logic [31:0] a, int hold_pre = 1, int hold_post = 1);
    ahold = 1; step(hold_pre);
    eads_n = 0; addr_in = a; step();
    eads_n = 1; addr_in = $urandom; step(hold_post);
    ahold = 0; step(2);
  endtask

  function automatic logic [31:0] mk(int unsigned tag, int idx, int offs);
    return {tag[23:0], 4'(idx), 4'(offs)};
  endfunction

  initial begin
    step(3);
    cur_req = "R1";                     // R1: reset values
    rst_n = 1; step(2);
    cur_req = "R6";                     // empty directory: all misses
    snoop(mk(0, 0, 0));
    cur_req = "R8";                     // fill every line
    for (int i = 0; i < 16; i++) begin
      cpu_addr = 32'h1000_0000 + i;
      fill(mk(24'hA0_0000 + i, i, i));
    end
    step();
    cur_req = "R5";                     // hits, offset bits differ
    for (int i = 0; i < 16; i += 3) snoop(mk(24'hA0_0000 + i, i, 15 - i), 1 + (i % 3), 1 + (i % 2));
    cur_req = "R6";                     // repeat snoops now miss; aliasing tags miss
    snoop(mk(24'hA0_0000, 0, 0));
    snoop(mk(24'hB0_0001, 1, 0));
    cur_req = "R7";                     // strobe without hold
    eads_n = 0; addr_in = mk(24'hA0_0001, 1, 0); step(); eads_n = 1; step(2);
    cur_req = "R5";                     // line 1 still valid
    snoop(mk(24'hA0_0001, 1, 0));
    cur_req = "R2";                     // long hold, back-to-back strobes
    ahold = 1; step(3);
    eads_n = 0; addr_in = mk(24'hA0_0002, 2, 0); step();
    addr_in = mk(24'hA0_0004, 4, 0); step();
    eads_n = 1; step(3); ahold = 0; step(2);
    cur_req = "R9";                     // fill and invalidate on same line/edge
    fill(mk(24'hC0_0005, 5, 0));
    ahold = 1; step();
    eads_n = 0; addr_in = mk(24'hC0_0005, 5, 0); step();
    eads_n = 1; fill_valid = 1; fill_addr = mk(24'hD0_0005, 5, 0); step();
    fill_valid = 0; ahold = 0; step(2);
    snoop(mk(24'hD0_0005, 5, 0));       // must miss
    cur_req = "R8";                     // refill works, then hits
    fill(mk(24'hD0_0005, 5, 7));
    snoop(mk(24'hD0_0005, 5, 0));
    cur_req = "R1";                     // reset mid-run clears lines
    fill(mk(24'hE0_0006, 6, 0));
    rst_n = 0; step(2); rst_n = 1; step();
    snoop(mk(24'hE0_0006, 6, 0));
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule